// File: doc/BRIEF.md
# ADC Result Coherency Controller

This block is the digital side of a successive-approximation ADC for a small byte-wide processor. Software sees four byte registers: a control register, an upper result byte, a lower result byte and a status byte that holds the end-of-conversion flag. On the converter side, the block drives a power enable, a one-cycle start strobe and a channel number. It receives a one-cycle done strobe together with the conversion code.

While enabled, the block converts continuously on the selected channel and raises an interrupt request if interrupts are allowed. Reading the lower result byte freezes both result bytes, so the next read of the upper byte returns the matching half of the same sample. Results that finish while the registers are frozen are thrown away. The freeze ends when the upper byte is read or when the block is disabled. Writing a different channel while converting restarts the conversion on the new channel.

Top module: `adc_coherent_regs`

## Requirements
- R1: After reset, every register reads 0x00 and `irq`, `conv_power` and `conv_start` are low.
- R2: When a done strobe is accepted, the result is captured. The upper byte (address 1) holds code bits 9..2. The lower byte (address 2) holds code bits 1..0 in bits 1..0 and zero elsewhere. Status (address 3) bit 0, the end-of-conversion flag, becomes 1.
- R3: `irq` is high exactly while the end-of-conversion flag is set and control bit 6, the interrupt enable, is 1.
- R4: A read of the upper byte clears the end-of-conversion flag. That read alone returns code bits 9..2 of the latest captured result.
- R5: A read of the lower byte while enabled freezes both result bytes. Results that finish while frozen are discarded and not buffered, so neither the bytes nor the flag change.
- R6: The freeze is released by a read of the upper byte or by clearing control bit 7, the enable.
- R7: A control write (address 0) that keeps bit 7 at 1 and changes bits 2..0, the channel, pulses `conv_start` in the next cycle with `conv_chan` equal to the new channel. The conversion in flight is abandoned.
- R8: While enabled, `conv_start` pulses in the cycle after each accepted done strobe, so conversion runs continuously.
- R9: While control bit 7 is 0, `conv_power` is low and no start strobe is issued.
- R10: The control register reads back the byte last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 upper result, 2 lower result, 3 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects act on this cycle) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | End-of-conversion interrupt request |
| conv_power | output | 1 | Converter enable |
| conv_start | output | 1 | One-cycle start strobe |
| conv_chan | output | CH_W | Channel to convert |
| conv_done | input | 1 | One-cycle completion strobe from the converter |
| conv_code | input | RES_W | Conversion code, valid with `conv_done` |

## Verification
The properties assume the converter never raises `conv_done` unless a conversion was started and is still powered. They also assume the bus never asserts read and write in the same cycle. The converter stub in the bench meets both assumptions: it answers only a start strobe, restarts its latency count on every new start, and drops any conversion when power goes low. The bus tasks issue one access at a time. Channel changes are issued only while converting, so the restart property is checked where it applies.

// File: rtl/adc_coh_pkg.sv
package adc_coh_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_RHI  = 2'd1,
    SEL_RLO  = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT = 7;
  localparam int CTRL_IE_BIT = 6;
endpackage

// File: rtl/adc_coh_regif.sv
module adc_coh_regif
  import adc_coh_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      ctrl_q,
  output logic            en_q,
  output logic            ien_q,
  output logic            ien_nx,
  output logic [CH_W-1:0] chan_q,
  output logic            rd_hi,
  output logic            rd_lo,
  output logic            ev_start,
  output logic            ev_stop
);
  logic wr_ctrl;
  logic new_en;

  assign wr_ctrl = bus_wr && (bus_addr == SEL_CTRL);
  assign new_en  = bus_wdata[CTRL_EN_BIT];
  assign rd_hi   = bus_rd && (bus_addr == SEL_RHI);
  assign rd_lo   = bus_rd && (bus_addr == SEL_RLO);

  assign en_q   = ctrl_q[CTRL_EN_BIT];
  assign ien_q  = ctrl_q[CTRL_IE_BIT];
  assign chan_q = ctrl_q[CH_W-1:0];
  assign ien_nx = wr_ctrl ? bus_wdata[CTRL_IE_BIT] : ien_q;

  // start: enable rising, or channel change while staying enabled
  assign ev_start = wr_ctrl && new_en &&
                    (!en_q || (bus_wdata[CH_W-1:0] != chan_q));
  assign ev_stop  = wr_ctrl && !new_en && en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata;
    end
  end
endmodule

// File: rtl/adc_coh_seq.sv
module adc_coh_seq (
  input  logic clk,
  input  logic rst,
  input  logic ev_start,
  input  logic ev_stop,
  input  logic conv_done,
  output logic done_ok,
  output logic start_q,
  output logic busy_q
);
  // a done strobe counts only for a live conversion not being stopped
  assign done_ok = conv_done && busy_q && !ev_stop;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (ev_stop) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else if (ev_start || done_ok) begin
      start_q <= 1'b1;
      busy_q  <= 1'b1;
    end else begin
      start_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_coh_result.sv
module adc_coh_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             ien_nx,
  input  logic             ev_stop,
  input  logic             rd_hi,
  input  logic             rd_lo,
  input  logic             done_ok,
  input  logic [RES_W-1:0] code,
  output logic [RES_W-1:0] res_q,
  output logic             eoc_q,
  output logic             lock_q,
  output logic             irq_q
);
  logic take;
  logic eoc_n;
  logic lock_n;

  // a result landing on the low-byte read edge would split the pair: drop it
  assign take = done_ok && !lock_q && !rd_lo;

  always_comb begin
    eoc_n = eoc_q;
    if (rd_hi) eoc_n = 1'b0;
    if (take)  eoc_n = 1'b1;

    lock_n = lock_q;
    if (rd_lo && en_q)    lock_n = 1'b1;
    if (rd_hi || ev_stop) lock_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      eoc_q  <= 1'b0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (take) res_q <= code;
      eoc_q  <= eoc_n;
      lock_q <= lock_n;
      irq_q  <= eoc_n && ien_nx;
    end
  end
endmodule

// File: rtl/adc_coherent_regs.sv
module adc_coherent_regs
  import adc_coh_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             irq,
  output logic             conv_power,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_code
);
  localparam int LO_W = RES_W - 8;

  logic [7:0]       ctrl_q;
  logic             en_q, ien_q, ien_nx;
  logic [CH_W-1:0]  chan_q;
  logic             rd_hi, rd_lo, ev_start, ev_stop;
  logic             done_ok, busy_q;
  logic [RES_W-1:0] res_q;
  logic             eoc_q, lock_q;
  logic [7:0]       lo_byte;
  logic [7:0]       rd_mux;

  adc_coh_regif #(.CH_W(CH_W)) u_regif (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .ctrl_q(ctrl_q),
    .en_q(en_q), .ien_q(ien_q), .ien_nx(ien_nx), .chan_q(chan_q),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .ev_start(ev_start), .ev_stop(ev_stop)
  );

  adc_coh_seq u_seq (
    .clk(clk), .rst(rst), .ev_start(ev_start), .ev_stop(ev_stop),
    .conv_done(conv_done), .done_ok(done_ok), .start_q(conv_start),
    .busy_q(busy_q)
  );

  adc_coh_result #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst(rst), .en_q(en_q), .ien_nx(ien_nx), .ev_stop(ev_stop),
    .rd_hi(rd_hi), .rd_lo(rd_lo), .done_ok(done_ok), .code(conv_code),
    .res_q(res_q), .eoc_q(eoc_q), .lock_q(lock_q), .irq_q(irq)
  );

  generate
    if (LO_W >= 8) begin : g_lo_full
      assign lo_byte = res_q[7:0];
    end else begin : g_lo_pad
      assign lo_byte = {{(8-LO_W){1'b0}}, res_q[LO_W-1:0]};
    end
  endgenerate

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_RHI:  rd_mux = res_q[RES_W-1 -: 8];
      SEL_RLO:  rd_mux = lo_byte;
      default:  rd_mux = {7'b0, eoc_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  assign conv_power = en_q;
  assign conv_chan  = chan_q;
endmodule

// File: rtl/adc_coh_checker.sv
module adc_coh_checker #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       bus_addr,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_wdata,
  input logic             irq,
  input logic             ien_q,
  input logic             conv_power,
  input logic             conv_start,
  input logic [CH_W-1:0]  conv_chan,
  input logic             conv_done,
  input logic [RES_W-1:0] res_q,
  input logic             eoc_q,
  input logic             lock_q
);
  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (rst)
    !ien_q |-> !irq);

  assert_hi_read_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd1 && !conv_done) |=> !eoc_q);

  assert_frozen_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !(bus_rd && bus_addr == 2'd1)) |=> $stable(res_q));

  assert_unlock_off_R6: assert property (@(posedge clk) disable iff (rst)
    !conv_power |-> !lock_q);

  assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd0 && bus_wdata[7] && conv_power &&
     bus_wdata[CH_W-1:0] != conv_chan) |=> (conv_start && conv_chan == $past(bus_wdata[CH_W-1:0])));

  assert_continuous_R8: assert property (@(posedge clk) disable iff (rst)
    (conv_done && conv_power && !bus_wr) |=> conv_start);

  assert_no_start_off_R9: assert property (@(posedge clk) disable iff (rst)
    !conv_power |-> !conv_start);
endmodule

bind adc_coherent_regs adc_coh_checker #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .irq(irq), .ien_q(ien_q),
  .conv_power(conv_power), .conv_start(conv_start), .conv_chan(conv_chan),
  .conv_done(conv_done), .res_q(res_q), .eoc_q(eoc_q), .lock_q(lock_q)
);

// File: tb/adc_coherent_regs_test.sv
module adc_coherent_regs_test;
  localparam int CH_W  = 3;
  localparam int RES_W = 10;
  localparam int LAT   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, conv_power, conv_start;
  logic [CH_W-1:0] conv_chan;
  logic conv_done;
  logic [RES_W-1:0] conv_code;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_coherent_regs #(.CH_W(CH_W), .RES_W(RES_W)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .conv_power(conv_power), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_code(conv_code)
  );

  // converter stub: fixed latency, code = {channel, sequence number}
  logic [3:0] lat_cnt;
  logic [CH_W-1:0] stub_ch;
  logic [6:0] stub_n;
  logic [RES_W-1:0] stub_last;

  always_ff @(posedge clk) begin
    conv_done <= 1'b0;
    if (rst || !conv_power) begin
      lat_cnt <= '0;
      stub_n  <= '0;
      stub_ch <= '0;
      conv_code <= '0;
    end else if (conv_start) begin
      lat_cnt <= 4'(LAT);
      stub_ch <= conv_chan;
    end else if (lat_cnt == 4'd1) begin
      lat_cnt   <= '0;
      conv_done <= 1'b1;
      conv_code <= {stub_ch, stub_n};
      stub_n    <= stub_n + 7'd1;
    end else if (lat_cnt != 0) begin
      lat_cnt <= lat_cnt - 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stub_last <= '0;
    else if (conv_done) stub_last <= conv_code;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  logic [RES_W-1:0] snap;

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    snap = stub_last;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wait_eoc(input string req);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 100; i++) begin
      bus_read(2'd3, s);
      if (s[0]) break;
    end
    check(s[0] == 1'b1, req, s, 1);
  endtask

  // R8 monitor: start follows each done while powered
  bit prev_done = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done && conv_power && !bus_wr)
        check(conv_start == 1'b1, "R8", conv_start, 1);
      prev_done = conv_done;
    end
  end

  // R9 monitor
  always @(negedge clk) begin
    if (!rst && !conv_power && conv_start)
      check(1'b0, "R9", conv_start, 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, lo, hi;
    logic [RES_W-1:0] exp;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    check(irq == 0 && conv_power == 0 && conv_start == 0, "R1", {irq, conv_power, conv_start}, 0);
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d);
      check(d == 8'h00, "R1", d, 0);
    end

    // R10: control readback; enable, irq enable, channel 5
    bus_write(2'd0, 8'hC5);
    bus_read(2'd0, d);
    check(d == 8'hC5, "R10", d, 8'hC5);
    check(conv_power == 1'b1, "R9", conv_power, 1);

    // R2 / R3 / R4: captured layout, irq, 8-bit read
    wait_eoc("R2");
    check(irq == 1'b1, "R3", irq, 1);
    bus_read(2'd1, hi);
    exp = snap;
    check(hi == exp[9:2], "R4", hi, exp[9:2]);
    check(hi[7:5] == 3'd5, "R2", hi[7:5], 5);
    bus_read(2'd3, d);
    check(d == 8'h00, "R4", d, 0);

    // R3: irq disabled while conversions keep finishing
    bus_write(2'd0, 8'h85);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(irq == 1'b0, "R3", irq, 0);
    end
    bus_read(2'd3, d);
    check(d == 8'h01, "R2", d, 1);
    bus_write(2'd0, 8'hC5);
    @(negedge clk);
    check(irq == 1'b1, "R3", irq, 1);

    // R5 / R6 sweep: 10-bit reads over every channel and lock duration
    for (int ch = 0; ch < 8; ch++) begin
      bus_write(2'd0, 8'h80 | 8'(ch));
      for (int k = 0; k < 13; k++) begin
        bus_read(2'd1, d);
        wait_eoc("R2");
        bus_read(2'd2, lo);
        exp = snap;
        repeat (k) @(negedge clk);
        bus_read(2'd1, hi);
        check(lo == {6'b0, exp[1:0]}, "R5", lo, {6'b0, exp[1:0]});
        check(hi == exp[9:2], "R5", hi, exp[9:2]);
        check(hi[7:5] == 3'(ch), "R7", hi[7:5], ch);
      end
    end

    // R5: discarded results are not buffered
    bus_read(2'd1, d);
    wait_eoc("R2");
    bus_read(2'd2, lo);
    repeat (30) @(negedge clk);
    bus_read(2'd3, d);
    check(d == 8'h01, "R5", d, 1);
    bus_read(2'd1, hi);
    bus_read(2'd3, d);
    check(d == 8'h00, "R5", d, 0);

    // R7: channel change restarts immediately
    bus_write(2'd0, 8'h82);
    repeat (3) @(negedge clk);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h86; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    check(conv_start == 1'b1, "R7", conv_start, 1);
    check(conv_chan == 3'd6, "R7", conv_chan, 6);
    bus_read(2'd1, d);
    wait_eoc("R7");
    bus_read(2'd1, hi);
    check(hi[7:5] == 3'd6, "R7", hi[7:5], 6);

    // R6 / R9: disable releases the freeze and halts conversion
    bus_read(2'd1, d);
    wait_eoc("R2");
    bus_read(2'd2, lo);
    bus_write(2'd0, 8'h03);
    check(conv_power == 1'b0, "R9", conv_power, 0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check(conv_start == 1'b0 && conv_done == 1'b0, "R9", {conv_start, conv_done}, 0);
    end
    bus_write(2'd0, 8'h83);
    repeat (30) @(negedge clk);
    bus_read(2'd1, hi);
    exp = snap;
    check(hi == exp[9:2], "R6", hi, exp[9:2]);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule